// File: doc/BRIEF.md
# Synchronous Serial Shift Port with Address Wake-Up

This block is a byte-wide synchronous serial channel controlled through a small register port. It has two wiring options. The three-wire option has a separate input pin and a push-pull output pin. The two-wire bus option has one shared data line, and the block only ever pulls that line low, as an open-drain output would. The shift clock comes from one of three sources: the external clock pin, the rising edges of a timer output, or a divided system clock whose divisor is set by a prescale register.

Software starts a transfer by writing the shift register while the channel is enabled and idle. In the two-wire option with the external clock selected, a start condition on the bus also starts a receive. After a start, the next received byte is treated as an address. In wake-up mode, transfer-complete interrupts are held back unless that address byte equals the programmed slave address. A read-only flag reports whether the shift register currently equals the slave address.

Top module: `sshift_port`

## Requirements
- R1: Register map: address 0 is the mode register (bit 7 enable, bit 6 read-only match flag, bit 5 wake-up, bit 4 two-wire option, bit 3 LSB-first, bit 2 reads 0, bits 1:0 clock source). Address 1 is the shift register, address 2 is the slave address and address 3 is the prescale select. After reset every register reads 0, irq is 0, sck_oe and sda_oe are 0, and so_o is 1.
- R2: While enable is 0, a shift register write stores the data but starts no transfer, no clock is driven and no irq is raised.
- R3: The match flag reads 1 exactly when enable is 1 and the shift register equals the slave address. Otherwise it reads 0.
- R4: With wake-up off, every completed 8-bit transfer raises irq for exactly one cycle.
- R5: With wake-up on, irq is raised only when the byte received after a start condition equals the slave address. A mismatching byte raises no irq and still lands in the shift register.
- R6: A shift register write while wake-up is 1 is ignored, and the register keeps its old value.
- R7: Clock source 0 is the sck_i pin, 1 is timer rising edges and 2 or 3 is the prescaled system clock. With the prescaled clock, each clock half-period is 2^(sel+1) system cycles, and the transfer completes after 16 half-periods.
- R8: In the two-wire option with the timer source, the shift clock toggles once every 16 timer rising edges.
- R9: In the three-wire option with the external clock, the outgoing bit changes after a falling sck_i edge and the incoming bit on si_i is sampled at the rising edge. The order is MSB first when bit 3 is 0 and LSB first when it is 1.
- R10: In the two-wire option, sck_o is always 0 and lines are only pulled low through the output enables. Shifting is always MSB first, whatever bit 3 says.
- R11: With enable set, the two-wire option and the external clock, a falling data line while the clock line is high starts a receive of one byte and arms the address comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| tmr_i | input | 1 | Timer output used as a clock source |
| sck_i | input | 1 | Serial clock pin level |
| sck_o | output | 1 | Serial clock value driven when sck_oe is 1 |
| sck_oe | output | 1 | Serial clock output enable |
| si_i | input | 1 | Three-wire serial data in |
| so_o | output | 1 | Three-wire serial data out |
| sda_i | input | 1 | Two-wire data line level |
| sda_oe | output | 1 | Two-wire data line pull-low enable |
| irq | output | 1 | Transfer-complete interrupt pulse |

## Verification
A bit counter that has slipped shows up as a shift register value that is rotated or off by one bit after a byte, or as an irq that comes one clock edge early or late. Both appear within one transfer. A wrong arm or compare state shows within a single addressed byte: irq is missing or appears on a mismatch. A broken direction or open-drain setting shows on the first falling clock edge, as the wrong level on so_o or sda_oe. A prescaler or timer divider fault shows as a transfer time outside the expected window, or as the clock being pulled low on the wrong timer edge.

// File: rtl/sshift_pkg.sv
package sshift_pkg;
   localparam int unsigned ADDR_W = 2;

   localparam logic [ADDR_W-1:0] A_MODE  = 2'd0;
   localparam logic [ADDR_W-1:0] A_SHIFT = 2'd1;
   localparam logic [ADDR_W-1:0] A_SVA   = 2'd2;
   localparam logic [ADDR_W-1:0] A_PSEL  = 2'd3;

   localparam int unsigned B_EN    = 7;
   localparam int unsigned B_MATCH = 6;
   localparam int unsigned B_WAKE  = 5;
   localparam int unsigned B_TWO   = 4;
   localparam int unsigned B_LSB   = 3;

   typedef enum logic [1:0] {
      SRC_EXT   = 2'b00,
      SRC_TMR   = 2'b01,
      SRC_PRE   = 2'b10,
      SRC_PRE_B = 2'b11
   } clk_src_e;

   typedef struct packed {
      logic     en;
      logic     wake;
      logic     two;
      logic     lsb;
      clk_src_e src;
   } mode_t;
endpackage

// File: rtl/sshift_sync.sv
module sshift_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] rst_val,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("sshift_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [W-1:0] stage [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage[i] <= rst_val;
      end else begin
         stage[0] <= d;
         for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/sshift_clkgen.sv
module sshift_clkgen #(
   parameter int unsigned PS_W    = 2,
   parameter int unsigned TMR_DIV = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            two,
   input  logic [1:0]      src,
   input  logic [PS_W-1:0] ps_sel,
   input  logic            tmr_s,
   output logic            tick
);
   localparam int unsigned PS_CNT_W = (1 << PS_W) + 1;
   localparam int unsigned DIV_W    = (TMR_DIV > 1) ? $clog2(TMR_DIV) : 1;

   logic                tmr_prev;
   logic                tmr_rise;
   logic [PS_CNT_W-1:0] ps_cnt;
   logic [PS_CNT_W-1:0] ps_lim;
   logic                ps_tick;
   logic                tmr_tick;

   assign tmr_rise = tmr_s & ~tmr_prev;
   assign ps_lim   = PS_CNT_W'((1 << (ps_sel + 1)) - 1);
   assign ps_tick  = (ps_cnt >= ps_lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_prev <= 1'b0;
         ps_cnt   <= '0;
      end else begin
         tmr_prev <= tmr_s;
         if (!en || ps_tick) ps_cnt <= '0;
         else                ps_cnt <= ps_cnt + 1'b1;
      end
   end

   generate
      if (TMR_DIV > 1) begin : g_tmr_div
         logic [DIV_W-1:0] div_cnt;
         logic             div_last;
         assign div_last = (div_cnt == DIV_W'(TMR_DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_cnt <= '0;
            end else if (!en || !two) begin
               div_cnt <= '0;
            end else if (tmr_rise) begin
               div_cnt <= div_last ? '0 : div_cnt + 1'b1;
            end
         end
         assign tmr_tick = two ? (tmr_rise & div_last) : tmr_rise;
      end else begin : g_tmr_nodiv
         assign tmr_tick = tmr_rise;
      end
   endgenerate

   always_comb begin
      unique case (src)
         2'b00:   tick = 1'b0;
         2'b01:   tick = tmr_tick;
         default: tick = ps_tick;
      endcase
      if (!en) tick = 1'b0;
   end
endmodule

// File: rtl/sshift_core.sv
module sshift_core #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              msb_first,
   input  logic              int_clk,
   input  logic              tick,
   input  logic              sck_s,
   input  logic              din,
   input  logic              wr_sr,
   input  logic              go,
   input  logic              start_rx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] sr,
   output logic              busy,
   output logic              clk_q,
   output logic              so_q,
   output logic              done
);
   localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic             sck_prev;
   logic             rx_only;
   logic [CNT_W-1:0] cnt;
   logic             ev_fall;
   logic             ev_rise;
   logic             out_bit;
   logic [DATA_W-1:0] sr_next;

   always_comb begin
      if (int_clk) begin
         ev_fall = tick & clk_q;
         ev_rise = tick & ~clk_q;
      end else begin
         ev_fall = sck_prev & ~sck_s;
         ev_rise = ~sck_prev & sck_s;
      end
      out_bit = msb_first ? sr[DATA_W-1] : sr[0];
      sr_next = msb_first ? {sr[DATA_W-2:0], din} : {din, sr[DATA_W-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_prev <= 1'b1;
         sr       <= '0;
         busy     <= 1'b0;
         rx_only  <= 1'b0;
         cnt      <= '0;
         clk_q    <= 1'b1;
         so_q     <= 1'b1;
         done     <= 1'b0;
      end else begin
         sck_prev <= sck_s;
         done     <= 1'b0;
         if (!en) begin
            busy    <= 1'b0;
            rx_only <= 1'b0;
            cnt     <= '0;
            clk_q   <= 1'b1;
            so_q    <= 1'b1;
            if (wr_sr) sr <= wdata;
         end else if (start_rx) begin
            busy    <= 1'b1;
            rx_only <= 1'b1;
            cnt     <= '0;
            clk_q   <= 1'b1;
            so_q    <= 1'b1;
         end else if (wr_sr) begin
            sr      <= wdata;
            busy    <= go;
            rx_only <= 1'b0;
            cnt     <= '0;
            clk_q   <= 1'b1;
         end else if (busy) begin
            if (ev_fall) begin
               so_q <= rx_only ? 1'b1 : out_bit;
               if (int_clk) clk_q <= 1'b0;
            end
            if (ev_rise) begin
               sr  <= sr_next;
               cnt <= cnt + 1'b1;
               if (int_clk) clk_q <= 1'b1;
               if (cnt == LAST) begin
                  busy <= 1'b0;
                  done <= 1'b1;
                  so_q <= 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/sshift_addr.sv
module sshift_addr #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              two,
   input  logic              wake,
   input  logic              sck_s,
   input  logic              sda_s,
   input  logic              done,
   input  logic [DATA_W-1:0] sr,
   input  logic [DATA_W-1:0] sva,
   output logic              start,
   output logic              match,
   output logic              irq
);
   logic scl_prev;
   logic sda_prev;
   logic armed;

   assign start = en & two & scl_prev & sck_s & sda_prev & ~sda_s;
   assign match = en & (sr == sva);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
         armed    <= 1'b0;
         irq      <= 1'b0;
      end else begin
         scl_prev <= sck_s;
         sda_prev <= sda_s;
         irq      <= en & done & (~wake | (armed & (sr == sva)));
         if (!en)       armed <= 1'b0;
         else if (start) armed <= 1'b1;
         else if (done)  armed <= 1'b0;
      end
   end
endmodule

// File: rtl/sshift_port.sv
module sshift_port #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned PS_W        = 2,
   parameter int unsigned TMR_DIV     = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              tmr_i,
   input  logic              sck_i,
   output logic              sck_o,
   output logic              sck_oe,
   input  logic              si_i,
   output logic              so_o,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic              irq
);
   import sshift_pkg::*;

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("sshift_port: DATA_W must be at least 8");
      end
      if (PS_W < 1 || PS_W > 4) begin : g_bad_ps
         $error("sshift_port: PS_W must be 1 to 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sshift_port: SYNC_STAGES must be at least 2");
      end
   endgenerate

   mode_t             mode_q;
   logic [PS_W-1:0]   ps_sel_q;
   logic [DATA_W-1:0] sva_q;

   logic              mode_en;
   logic              mode_wake;
   logic              mode_2w;
   logic              int_clk;
   logic              tmr_s, sck_s, si_s, sda_s;
   logic              tick;
   logic              wr_sr, go, start, start_rx;
   logic [DATA_W-1:0] sr_val;
   logic              busy, clk_q, so_q, done;
   logic              match_flag;

   assign mode_en   = mode_q.en;
   assign mode_wake = mode_q.wake;
   assign mode_2w   = mode_q.two;
   assign int_clk   = (mode_q.src != SRC_EXT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= '0;
         ps_sel_q <= '0;
         sva_q    <= '0;
      end else if (reg_we) begin
         unique case (reg_addr)
            A_MODE: begin
               mode_q.en   <= reg_wdata[B_EN];
               mode_q.wake <= reg_wdata[B_WAKE];
               mode_q.two  <= reg_wdata[B_TWO];
               mode_q.lsb  <= reg_wdata[B_LSB];
               mode_q.src  <= clk_src_e'(reg_wdata[1:0]);
            end
            A_SVA:   sva_q    <= reg_wdata;
            A_PSEL:  ps_sel_q <= reg_wdata[PS_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         A_MODE: begin
            reg_rdata[B_EN]    = mode_q.en;
            reg_rdata[B_MATCH] = match_flag;
            reg_rdata[B_WAKE]  = mode_q.wake;
            reg_rdata[B_TWO]   = mode_q.two;
            reg_rdata[B_LSB]   = mode_q.lsb;
            reg_rdata[1:0]     = mode_q.src;
         end
         A_SHIFT: reg_rdata = sr_val;
         A_SVA:   reg_rdata = sva_q;
         default: reg_rdata[PS_W-1:0] = ps_sel_q;
      endcase
   end

   sshift_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .rst_val (4'b0111),
      .d       ({tmr_i, sck_i, si_i, sda_i}),
      .q       ({tmr_s, sck_s, si_s, sda_s})
   );

   sshift_clkgen #(.PS_W(PS_W), .TMR_DIV(TMR_DIV)) u_clkgen (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (mode_en),
      .two    (mode_2w),
      .src    (mode_q.src),
      .ps_sel (ps_sel_q),
      .tmr_s  (tmr_s),
      .tick   (tick)
   );

   assign wr_sr    = reg_we & (reg_addr == A_SHIFT) & ~mode_wake & ~busy;
   assign go       = wr_sr & mode_en;
   assign start_rx = start & ~int_clk;

   sshift_core #(.DATA_W(DATA_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (mode_en),
      .msb_first (mode_2w | ~mode_q.lsb),
      .int_clk   (int_clk),
      .tick      (tick),
      .sck_s     (sck_s),
      .din       (mode_2w ? sda_s : si_s),
      .wr_sr     (wr_sr),
      .go        (go),
      .start_rx  (start_rx),
      .wdata     (reg_wdata),
      .sr        (sr_val),
      .busy      (busy),
      .clk_q     (clk_q),
      .so_q      (so_q),
      .done      (done)
   );

   sshift_addr #(.DATA_W(DATA_W)) u_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (mode_en),
      .two   (mode_2w),
      .wake  (mode_wake),
      .sck_s (sck_s),
      .sda_s (sda_s),
      .done  (done),
      .sr    (sr_val),
      .sva   (sva_q),
      .start (start),
      .match (match_flag),
      .irq   (irq)
   );

   assign sck_o  = mode_2w ? 1'b0 : clk_q;
   assign sck_oe = mode_en & int_clk & (mode_2w ? ~clk_q : 1'b1);
   assign so_o   = mode_2w ? 1'b1 : so_q;
   assign sda_oe = mode_en & mode_2w & ~so_q;
endmodule

// File: rtl/sshift_port_chk.sv
module sshift_port_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq,
   input logic              mode_en,
   input logic              mode_wake,
   input logic              mode_2w,
   input logic              match_flag,
   input logic              busy,
   input logic              reg_we,
   input logic [1:0]        reg_addr,
   input logic [DATA_W-1:0] sr_val,
   input logic              sck_o,
   input logic              sda_oe
);
   // R4
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R4
   done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && mode_en && !mode_wake) |=> irq);

   // R3
   match_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_en |-> !match_flag);

   // R5
   wake_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && mode_wake) |-> match_flag);

   // R6
   wake_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 2'd1 && mode_wake && !busy) |=> $stable(sr_val));

   // R10
   od_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_2w |-> (sck_o == 1'b0));

   // R10
   od_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_2w |-> !sda_oe);
endmodule

bind sshift_port sshift_port_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq        (irq),
   .mode_en    (mode_en),
   .mode_wake  (mode_wake),
   .mode_2w    (mode_2w),
   .match_flag (match_flag),
   .busy       (busy),
   .reg_we     (reg_we),
   .reg_addr   (reg_addr),
   .sr_val     (sr_val),
   .sck_o      (sck_o),
   .sda_oe     (sda_oe)
);

// File: tb/sshift_port_test.sv
`timescale 1ns/1ps
module sshift_port_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       tmr_i = 1'b0;
   logic       sck_bus = 1'b1;
   logic       sda_bus = 1'b1;
   logic       si_i = 1'b0;
   logic       sck_o, sck_oe, so_o, sda_oe, irq;
   logic       sck_i, sda_i;

   int checks = 0;
   int errors = 0;
   int irq_cnt = 0;

   always #2.5 clk = ~clk;

   assign sck_i = sck_bus & ~(sck_oe & ~sck_o);
   assign sda_i = sda_bus & ~sda_oe;

   sshift_port uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_i(tmr_i),
      .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .si_i(si_i),
      .so_o(so_o), .sda_i(sda_i), .sda_oe(sda_oe), .irq(irq)
   );

   always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic t_reset;
      logic [7:0] v;
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         chk("R1 reset register", v, 0);
      end
      chk("R1 reset irq", irq, 0);
      chk("R1 reset sck_oe", sck_oe, 0);
      chk("R1 reset sda_oe", sda_oe, 0);
      chk("R1 reset so_o", so_o, 1);
   endtask

   task automatic t_enable_match;
      logic [7:0] v;
      int base;
      base = irq_cnt;
      wr(2'd2, 8'h5A);
      wr(2'd1, 8'h5A);
      cyc(40);
      rd(2'd1, v);
      chk("R2 disabled write stores data", v, 8'h5A);
      chk("R2 disabled no clock", sck_oe, 0);
      chk("R2 disabled no irq", irq_cnt - base, 0);
      rd(2'd0, v);
      chk("R3 match forced low when disabled", v, 8'h00);
      wr(2'd0, 8'h80);
      rd(2'd0, v);
      chk("R3 match flag when enabled and equal", v, 8'hC0);
      wr(2'd2, 8'h5B);
      rd(2'd0, v);
      chk("R3 match flag clears on mismatch", v, 8'h80);
      wr(2'd2, 8'h5A);
      wr(2'd0, 8'h00);
   endtask

   task automatic t_wake_write;
      logic [7:0] v;
      wr(2'd0, 8'hA0);
      wr(2'd1, 8'h11);
      cyc(4);
      rd(2'd1, v);
      chk("R6 write ignored under wake-up", v, 8'h5A);
      rd(2'd0, v);
      chk("R6 mode readback with match", v, 8'hE0);
      wr(2'd0, 8'h00);
   endtask

   task automatic t_3w_ext(input logic lsb, input logic [7:0] tx, input logic [7:0] rx);
      logic [7:0] got;
      logic [7:0] v;
      int base;
      base = irq_cnt;
      wr(2'd0, lsb ? 8'h88 : 8'h80);
      wr(2'd1, tx);
      got = 8'h00;
      for (int i = 0; i < 8; i++) begin
         sck_bus = 1'b0;
         cyc(8);
         if (lsb) begin got[i] = so_o; si_i = rx[i]; end
         else     begin got[7-i] = so_o; si_i = rx[7-i]; end
         cyc(8);
         sck_bus = 1'b1;
         cyc(8);
      end
      rd(2'd1, v);
      chk(lsb ? "R9 LSB-first bits sent" : "R9 MSB-first bits sent", got, tx);
      chk(lsb ? "R9 LSB-first bits received" : "R9 MSB-first bits received", v, rx);
      chk("R4 one irq per transfer", irq_cnt - base, 1);
      wr(2'd0, 8'h00);
   endtask

   task automatic xfer_time(input logic [1:0] sel, output int t);
      int base;
      base = irq_cnt;
      wr(2'd3, {6'd0, sel});
      wr(2'd0, 8'h82);
      wr(2'd1, 8'hAA);
      t = 1;
      while (irq_cnt == base && t < 400) begin
         @(negedge clk);
         t++;
      end
      wr(2'd0, 8'h00);
   endtask

   task automatic t_prescale;
      int t0, t1;
      wr(2'd0, 8'h82);
      chk("R7 internal clock driven in three-wire", sck_oe, 1);
      chk("R7 idle clock high", sck_o, 1);
      xfer_time(2'd0, t0);
      xfer_time(2'd1, t1);
      chk("R7 sel 0 transfer time window", (t0 >= 28 && t0 <= 40) ? 1 : 0, 1);
      chk("R7 sel 1 transfer time window", (t1 >= 58 && t1 <= 72) ? 1 : 0, 1);
   endtask

   task automatic tmr_pulse;
      tmr_i = 1'b1; cyc(4);
      tmr_i = 1'b0; cyc(4);
   endtask

   task automatic t_2w_timer;
      wr(2'd0, 8'h99);
      wr(2'd1, 8'h7F);
      cyc(4);
      chk("R8 clock released before timer edges", sck_oe, 0);
      for (int i = 0; i < 15; i++) tmr_pulse();
      chk("R8 no clock edge after 15 timer edges", sck_oe, 0);
      chk("R10 data released before first fall", sda_oe, 0);
      tmr_pulse();
      chk("R8 clock pulled low on 16th timer edge", sck_oe, 1);
      chk("R10 clock value is low", sck_o, 0);
      chk("R10 MSB first forced: bit 7 zero pulls data low", sda_oe, 1);
      wr(2'd0, 8'h00);
      chk("R10 lines released when disabled", sck_oe | sda_oe, 0);
   endtask

   task automatic bus_byte(input logic [7:0] b);
      sck_bus = 1'b1; sda_bus = 1'b1; cyc(8);
      sda_bus = 1'b0; cyc(8);
      sck_bus = 1'b0; cyc(8);
      for (int i = 7; i >= 0; i--) begin
         sda_bus = b[i]; cyc(8);
         sck_bus = 1'b1; cyc(8);
         sck_bus = 1'b0; cyc(8);
      end
      sda_bus = 1'b0; cyc(8);
      sck_bus = 1'b1; cyc(8);
      sda_bus = 1'b1; cyc(8);
   endtask

   task automatic t_2w_bus(input logic wake, input logic [7:0] sva, input logic [7:0] b,
                           input int exp_irq, input string req);
      logic [7:0] v;
      int base;
      wr(2'd2, sva);
      wr(2'd0, wake ? 8'hB0 : 8'h90);
      base = irq_cnt;
      bus_byte(b);
      rd(2'd1, v);
      chk({req, " byte received after start"}, v, b);
      chk({req, " irq count"}, irq_cnt - base, exp_irq);
      chk("R10 no data drive during receive", sda_oe, 0);
      wr(2'd0, 8'h00);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      t_reset();
      t_enable_match();
      t_wake_write();
      t_3w_ext(1'b0, 8'hA5, 8'h3C);
      t_3w_ext(1'b1, 8'hA5, 8'h3C);
      t_prescale();
      t_2w_timer();
      t_2w_bus(1'b1, 8'h52, 8'h52, 1, "R5 R11 wake match");
      t_2w_bus(1'b1, 8'h52, 8'h53, 0, "R5 R11 wake mismatch");
      t_2w_bus(1'b0, 8'h00, 8'h3C, 1, "R4 R11 no wake");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #500000;
      errors++;
      $display("FAIL R1 watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule